// File: doc/BRIEF.md
# Lockstep Strided Array Line Fetcher

This block walks a group of arrays in step and asks a downstream lock stage to fetch and hold the cache lines that each loop iteration will read or write. Software first fills a small bank of descriptors, one for each array. A descriptor holds the array's base address, its element size, a load or store role, a data type tag, an element count and an active flag. A start pulse then launches a walk. The walk uses one shared iteration cursor that runs from zero up to the shortest active array. For each cursor value, the engine visits the active arrays in ascending descriptor order.

Every array is traversed with unit stride, so iteration i touches element i of every array. The engine sends a line request only when element i lands in a different line from element i-1 of the same array. Repeated hits on one line are merged into that line's single request. Each request also carries how many of the line's elements the remaining iterations will use, so the lock stage can set its reference count. A low ready from the lock stage, meaning no lockable line is free, stalls the walk. The walk resumes on its own once ready returns.

Top module: `array_refill_engine`

## Requirements
- R1: After reset, req_valid, busy and done are all low.
- R2: A cycle with cfg_we high writes every field of the descriptor selected by cfg_idx. cfg_esz encodes the element size as 0=1, 1=2, 2=4 and 3=8 bytes. Base addresses are assumed to be aligned to their element size.
- R3: A start pulse while idle sets the loop length L to the smallest count among active descriptors. Requests then come in cursor order 0..L-1, and within one cursor value in ascending descriptor index.
- R4: req_addr is base + i*size with its low log2(LINE_BYTES) bits cleared (LINE_BYTES=64 by default). A request is issued for element i only when i is 0 or this line differs from the line of element i-1.
- R5: req_uses equals the number of elements j in i..L-1 of that array whose line equals req_addr.
- R6: req_store, req_dtype and req_desc carry the role, type tag and index of the descriptor the request belongs to.
- R7: While req_valid is high and req_ready is low, req_valid, req_addr and req_desc hold. The walk moves past a request only on a cycle with both high, and it continues when ready returns, with no other input.
- R8: A descriptor whose active flag is clear never produces a request and does not shorten L.
- R9: After the last request of a walk transfers, busy falls and done rises. done holds until the next start. If L is 0, or no descriptor is active, done rises with no request.
- R10: Descriptor writes and start pulses are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | IDX_W | Descriptor to write |
| cfg_base | input | ADDR_W | Array base byte address |
| cfg_esz | input | 2 | Element size code |
| cfg_store | input | 1 | 1 = store role, 0 = load role |
| cfg_dtype | input | DTYPE_W | Data type tag |
| cfg_count | input | CNT_W | Element count |
| cfg_active | input | 1 | Descriptor takes part in the walk |
| start | input | 1 | Start pulse |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Lock stage accepts the line |
| req_addr | output | ADDR_W | Line-aligned address |
| req_desc | output | IDX_W | Requesting descriptor |
| req_store | output | 1 | Role of the requesting array |
| req_dtype | output | DTYPE_W | Type tag of the requesting array |
| req_uses | output | OFF_W+1 | Elements of this line the walk will use |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (sticky) |

## Verification
The hardest case to reach is a request held in a stall at the very moment software tries to rewrite a descriptor or restart the walk. If that write or restart leaked through, a stalled address could change or a walk could end early. The bench throttles ready to one cycle in four, which keeps requests parked for several cycles. During such a run it rewrites descriptor 0 and pulses start. It then checks that every request still matches the old configuration, and that a second run also shows the write had no effect. Mixed element sizes and a base that is not aligned to a line make lines break at different cursors across arrays, which exercises the merging and the reference counts.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {ESZ_B1 = 2'd0, ESZ_B2 = 2'd1, ESZ_B4 = 2'd2, ESZ_B8 = 2'd3} esz_e;
  localparam int DTYPE_W = 2;
endpackage

// File: rtl/refill_desc_bank.sv
module refill_desc_bank
  import refill_pkg::*;
#(
  parameter int N      = 6,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [ADDR_W-1:0]   wr_base,
  input  esz_e                wr_esz,
  input  logic                wr_store,
  input  logic [DTYPE_W-1:0]  wr_dtype,
  input  logic [CNT_W-1:0]    wr_count,
  input  logic                wr_active,
  output logic [ADDR_W-1:0]   base_o   [N],
  output esz_e                esz_o    [N],
  output logic                store_o  [N],
  output logic [DTYPE_W-1:0]  dtype_o  [N],
  output logic [CNT_W-1:0]    count_o  [N],
  output logic                active_o [N],
  output logic [CNT_W-1:0]    min_count_o,
  output logic                any_active_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[g]   <= '0;
        esz_o[g]    <= ESZ_B1;
        store_o[g]  <= 1'b0;
        dtype_o[g]  <= '0;
        count_o[g]  <= '0;
        active_o[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        base_o[g]   <= wr_base;
        esz_o[g]    <= wr_esz;
        store_o[g]  <= wr_store;
        dtype_o[g]  <= wr_dtype;
        count_o[g]  <= wr_count;
        active_o[g] <= wr_active;
      end
    end
  end

  // shortest active array sets the loop length
  always_comb begin
    min_count_o  = '1;
    any_active_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (active_o[k]) begin
        any_active_o = 1'b1;
        if (count_o[k] < min_count_o) min_count_o = count_o[k];
      end
    end
  end
endmodule

// File: rtl/refill_addr_gen.sv
module refill_addr_gen
  import refill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int OFF_W      = 6,
  parameter int UW         = 7
) (
  input  logic [ADDR_W-1:0] base,
  input  esz_e              esz,
  input  logic [CNT_W-1:0]  idx,
  input  logic [CNT_W-1:0]  limit,
  output logic [ADDR_W-1:0] line_addr,
  output logic              new_line,
  output logic [UW-1:0]     uses
);
  function automatic logic [ADDR_W-1:0] elem_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [CNT_W-1:0] i,
                                                  input logic [1:0] sh);
    return b + (ADDR_W'(i) << sh);
  endfunction

  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  logic [1:0]        sh;
  logic [ADDR_W-1:0] cur_a, prev_a;
  logic [UW-1:0]     per_line, slot, room;
  logic [CNT_W-1:0]  left;

  always_comb begin
    sh        = 2'(esz);
    cur_a     = elem_addr(base, idx, sh);
    prev_a    = elem_addr(base, idx - 1'b1, sh);
    line_addr = line_of(cur_a);
    new_line  = (idx == '0) || (line_of(prev_a) != line_addr);
    per_line  = UW'(LINE_BYTES) >> sh;
    slot      = {1'b0, cur_a[OFF_W-1:0]} >> sh;
    room      = per_line - slot;
    left      = limit - idx;
    uses      = (left < CNT_W'(room)) ? UW'(left) : room;
  end
endmodule

// File: rtl/array_refill_engine.sv
module array_refill_engine
  import refill_pkg::*;
#(
  parameter int N          = 6,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LINE_BYTES = 64,
  localparam int IDX_W     = (N > 1) ? $clog2(N) : 1,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int UW        = OFF_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [1:0]         cfg_esz,
  input  logic               cfg_store,
  input  logic [DTYPE_W-1:0] cfg_dtype,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic               cfg_active,
  input  logic               start,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [IDX_W-1:0]   req_desc,
  output logic               req_store,
  output logic [DTYPE_W-1:0] req_dtype,
  output logic [UW-1:0]      req_uses,
  output logic               busy,
  output logic               done
);
  logic [ADDR_W-1:0]  d_base   [N];
  esz_e               d_esz    [N];
  logic               d_store  [N];
  logic [DTYPE_W-1:0] d_dtype  [N];
  logic [CNT_W-1:0]   d_count  [N];
  logic               d_active [N];
  logic [CNT_W-1:0]   min_count;
  logic               any_active;

  logic               busy_q, done_q;
  logic [CNT_W-1:0]   cursor_q, limit_q;
  logic [IDX_W-1:0]   dptr_q;

  // named internal events
  logic cfg_accept, launch, issue, advance, last_desc, last_iter, empty_walk;
  logic new_line;
  logic [ADDR_W-1:0] line_addr;
  logic [UW-1:0]     uses;

  assign cfg_accept = cfg_we & ~busy_q;
  assign launch     = start & ~busy_q;
  assign empty_walk = ~any_active | (min_count == '0);

  refill_desc_bank #(.N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_accept), .wr_idx(cfg_idx),
    .wr_base(cfg_base), .wr_esz(esz_e'(cfg_esz)), .wr_store(cfg_store),
    .wr_dtype(cfg_dtype), .wr_count(cfg_count), .wr_active(cfg_active),
    .base_o(d_base), .esz_o(d_esz), .store_o(d_store), .dtype_o(d_dtype),
    .count_o(d_count), .active_o(d_active),
    .min_count_o(min_count), .any_active_o(any_active)
  );

  refill_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES),
                    .OFF_W(OFF_W), .UW(UW)) u_agen (
    .base(d_base[dptr_q]), .esz(d_esz[dptr_q]), .idx(cursor_q), .limit(limit_q),
    .line_addr(line_addr), .new_line(new_line), .uses(uses)
  );

  assign issue     = busy_q & d_active[dptr_q] & new_line;
  assign advance   = busy_q & (~issue | req_ready);
  assign last_desc = (dptr_q == IDX_W'(N - 1));
  assign last_iter = (cursor_q == limit_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cursor_q <= '0;
      limit_q  <= '0;
      dptr_q   <= '0;
    end else if (launch) begin
      cursor_q <= '0;
      dptr_q   <= '0;
      limit_q  <= min_count;
      busy_q   <= ~empty_walk;
      done_q   <= empty_walk;
    end else if (advance) begin
      if (last_desc) begin
        dptr_q <= '0;
        if (last_iter) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cursor_q <= cursor_q + 1'b1;
        end
      end else begin
        dptr_q <= dptr_q + 1'b1;
      end
    end
  end

  assign req_valid = issue;
  assign req_addr  = line_addr;
  assign req_desc  = dptr_q;
  assign req_store = d_store[dptr_q];
  assign req_dtype = d_dtype[dptr_q];
  assign req_uses  = uses;
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/refill_chk.sv
module refill_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 6,
  parameter int UW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [IDX_W-1:0]  req_desc,
  input logic [UW-1:0]     req_uses,
  input logic              busy,
  input logic              done
);
  // R7
  held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_desc));
  // R4
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[OFF_W-1:0] == '0);
  // R5
  uses_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_uses != '0);
  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done) && !(done && req_valid));
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy || done);
endmodule

bind array_refill_engine refill_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_desc(req_desc), .req_uses(req_uses), .busy(busy), .done(done)
);

// File: tb/test_array_refill_engine.sv
module test_array_refill_engine;
  localparam int N = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = 0;
  logic [31:0] cfg_base = 0;
  logic [1:0]  cfg_esz = 0;
  logic        cfg_store = 0;
  logic [1:0]  cfg_dtype = 0;
  logic [15:0] cfg_count = 0;
  logic        cfg_active = 0;
  logic        start = 0;
  logic        req_valid;
  logic        req_ready = 1;
  logic [31:0] req_addr;
  logic [2:0]  req_desc;
  logic        req_store;
  logic [1:0]  req_dtype;
  logic [6:0]  req_uses;
  logic        busy, done;

  array_refill_engine i_array_refill_engine (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, rdy_mode = 0, stall_bad = 0;
  // model descriptors
  int m_base[N], m_esz[N], m_cnt[N], m_act[N], m_st[N], m_dt[N];
  // captured and expected transfers
  int g_n = 0, e_n = 0;
  int g_addr[512], g_desc[512], g_uses[512], g_st[512], g_dt[512];
  int e_addr[512], e_desc[512], e_uses[512], e_st[512], e_dt[512];
  bit stall_p = 0;
  int p_addr = 0, p_desc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    req_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 4 == 3);
    #1;
    if (stall_p && (!req_valid || int'(req_addr) != p_addr || int'(req_desc) != p_desc))
      stall_bad++;
    stall_p = req_valid && !req_ready;
    p_addr  = int'(req_addr);
    p_desc  = int'(req_desc);
    if (req_valid && req_ready && g_n < 512) begin
      g_addr[g_n] = int'(req_addr); g_desc[g_n] = int'(req_desc);
      g_uses[g_n] = int'(req_uses); g_st[g_n] = int'(req_store);
      g_dt[g_n] = int'(req_dtype); g_n++;
    end
  end

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic write_desc(input int d, input int b, input int e, input int c,
                            input int a, input int s, input int t);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(d); cfg_base = 32'(b); cfg_esz = 2'(e);
    cfg_count = 16'(c); cfg_active = a[0]; cfg_store = s[0]; cfg_dtype = 2'(t);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_desc(input int d, input int b, input int e, input int c,
                          input int a, input int s, input int t);
    m_base[d] = b; m_esz[d] = e; m_cnt[d] = c; m_act[d] = a; m_st[d] = s; m_dt[d] = t;
    write_desc(d, b, e, c, a, s, t);
  endtask

  function automatic int lineof(input int d, input int i);
    return (m_base[d] + i * (1 << m_esz[d])) / 64 * 64;
  endfunction

  // expected transfers from the requirements (R3, R4, R5, R6, R8)
  task automatic build_expected();
    int len = -1;
    e_n = 0;
    for (int d = 0; d < N; d++)
      if (m_act[d] != 0 && (len < 0 || m_cnt[d] < len)) len = m_cnt[d];
    if (len < 0) len = 0;
    for (int i = 0; i < len; i++)
      for (int d = 0; d < N; d++) begin
        if (m_act[d] == 0) continue;
        if (i == 0 || lineof(d, i) != lineof(d, i - 1)) begin
          int u = 0;
          for (int j = i; j < len; j++) if (lineof(d, j) == lineof(d, i)) u++;
          e_addr[e_n] = lineof(d, i); e_desc[e_n] = d; e_uses[e_n] = u;
          e_st[e_n] = m_st[d]; e_dt[e_n] = m_dt[d]; e_n++;
        end
      end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic compare(input string tag);
    int bad = -1;
    chk(g_n == e_n, {tag, " request count"}, g_n, e_n);
    for (int k = 0; k < e_n && k < g_n; k++)
      if (bad < 0 && (g_addr[k] != e_addr[k] || g_desc[k] != e_desc[k] ||
          g_uses[k] != e_uses[k] || g_st[k] != e_st[k] || g_dt[k] != e_dt[k])) bad = k;
    if (bad >= 0)
      $display("FAIL %s entry %0d addr/desc/uses act=%0h/%0d/%0d exp=%0h/%0d/%0d", tag, bad,
               g_addr[bad], g_desc[bad], g_uses[bad], e_addr[bad], e_desc[bad], e_uses[bad]);
    n_chk++; if (bad >= 0) n_bad++;
    chk(done && !busy, {tag, " R9 done after walk"}, int'(done), 1);
  endtask

  task automatic run(input string tag);
    build_expected();
    g_n = 0;
    pulse_start();
    wait_done();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear_all();
    for (int d = 0; d < N; d++) set_desc(d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk(!req_valid && !busy && !done, "R1 reset state", int'({req_valid, busy, done}), 0);
  endtask

  task automatic t_single();
    clear_all();
    set_desc(0, 'h100, 2, 40, 1, 0, 1);
    run("R3 R4 R5 single array");
    chk(g_addr[0] == 'h100 && g_uses[0] == 16, "R4 R5 first line", g_uses[0], 16);
    chk(g_addr[2] == 'h180 && g_uses[2] == 8, "R5 tail line", g_uses[2], 8);
  endtask

  task automatic t_group();
    clear_all();
    set_desc(0, 'h1000, 0, 70, 1, 0, 0);
    set_desc(1, 'h2010, 1, 60, 1, 0, 1);
    set_desc(2, 'h3020, 2, 50, 1, 0, 2);
    set_desc(3, 'h41F8, 3, 45, 1, 0, 3);
    set_desc(4, 'h5004, 2, 48, 1, 0, 2);
    set_desc(5, 'h6000, 2, 99, 1, 1, 1);
    run("R2 R3 R6 six arrays");
  endtask

  task automatic t_inactive();
    clear_all();
    set_desc(1, 'h800, 3, 20, 1, 1, 3);
    set_desc(2, 'h900, 0, 3, 0, 0, 0);
    set_desc(4, 'hA00, 1, 33, 1, 0, 2);
    run("R8 inactive skipped");
    chk(g_st[0] == 1 && g_dt[0] == 3, "R6 role and type", g_dt[0], 3);
  endtask

  task automatic t_backpressure();
    clear_all();
    set_desc(0, 'h100, 2, 30, 1, 0, 1);
    set_desc(3, 'h7F0, 3, 30, 1, 1, 2);
    stall_bad = 0;
    rdy_mode = 1;
    build_expected();
    g_n = 0;
    pulse_start();
    repeat (7) @(negedge clk);
    write_desc(0, 'hFFC0, 0, 2, 1, 1, 3);
    pulse_start();
    wait_done();
    @(negedge clk);
    compare("R7 R10 throttled walk");
    chk(stall_bad == 0, "R7 held during stall", stall_bad, 0);
    run("R10 write ignored on rerun");
    rdy_mode = 0;
  endtask

  task automatic t_empty();
    clear_all();
    set_desc(2, 'h40, 1, 0, 1, 0, 0);
    run("R9 zero length");
    chk(g_n == 0, "R9 no request", g_n, 0);
    clear_all();
    run("R9 no active");
    repeat (3) @(negedge clk);
    chk(done && !busy, "R9 done sticky", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_group();
    t_inactive();
    t_backpressure();
    t_empty();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule